// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block turns a virtual page number into a physical frame number by searching a hashed page table held in an external word-addressed memory. The page number is folded into a bucket index. The block reads that bucket's head pointer from a bucket array placed at a programmable base address. It then walks the chain of elements behind that pointer, one element at a time, until an element's stored page number equals the requested one.

Each element is three consecutive memory words. The word at the element's own address holds the page number, the next word holds the frame, and the third holds the link to the following element. A link or head of zero ends the chain. A programmable cap on the number of elements compared stops a search that would otherwise circle forever in a corrupt, cyclic chain. Every search ends with a one-cycle result pulse. The pulse carries either a hit with the frame, or a fault that marks whether the chain ended or the cap was reached, together with the number of elements compared.

Top module: `hpt_walker`

## Requirements
- R1: The bucket index is the low IDX_W bits of the upper half of the page number XOR its lower half. The first memory read of every search is at `bucket_base` plus that index.
- R2: An element at address p keeps its page number at p, its frame at p+1 and its link at p+2. A compared element that does not match costs two reads (page number, link). A matching element costs two reads (page number, frame). Every search issues exactly 1 + 2×`res_visits` reads.
- R3: Along a chain, the first element whose page number equals the request supplies the frame. Later elements with the same page number are never reached.
- R4: A head or link of zero ends the search with `res_fault`=1, `res_overrun`=0 and `res_frame`=0. `res_visits` equals the number of elements compared, which is 0 for an empty bucket.
- R5: If a nonzero pointer would be followed after `max_len` elements have been compared, the search ends with `res_fault`=1, `res_overrun`=1 and `res_visits`=`max_len`. A match on the `max_len`-th element is still a hit. With `max_len`=0, any nonempty bucket overruns.
- R6: Each search ends with `res_valid` high for exactly one cycle. In that cycle exactly one of `res_hit` and `res_fault` is 1. A hit also reports the frame and the element count.
- R7: `busy` is high from the cycle after a request is taken until the result pulse. A `req_valid` seen while `busy` is high is ignored and produces no result.
- R8: `rd_req` stays high with `rd_addr` unchanged until the cycle in which `rd_ack` returns the data.
- R9: After reset, `busy`, `rd_req` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a search; taken only when idle |
| req_vpn | input | VPN_W | Page number to resolve |
| bucket_base | input | AW | Address of bucket 0's head pointer; hold stable during a search |
| max_len | input | CNT_W | Cap on elements compared; hold stable during a search |
| busy | output | 1 | Search in progress |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | AW | Memory read address |
| rd_ack | input | 1 | Read data valid for one cycle |
| rd_data | input | DW | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Page found |
| res_fault | output | 1 | Page not resolved |
| res_overrun | output | 1 | Fault caused by the length cap |
| res_frame | output | FRAME_W | Frame on a hit, zero on a fault |
| res_visits | output | CNT_W | Elements compared in this search |

## Verification
The hardest case to reach from the ports is the runaway walk. It needs a chain whose links point back into themselves, which a correct table never contains. The bench plants a two-element loop in one bucket and searches for a page that is in neither element, so only the cap can end the walk. The cap's edge is probed by setting it equal to, and one below, the depth of a real three-element chain, and by setting it to zero. The memory model counts acknowledged reads and records the first address, which exposes both the hash and the skipped frame reads.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VPN_W   = 16,
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int FRAME_W = 12,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [AW-1:0]      bucket_base,
  input  logic [CNT_W-1:0]   max_len,
  output logic               busy,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_ack,
  input  logic [DW-1:0]      rd_data,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_fault,
  output logic               res_overrun,
  output logic [FRAME_W-1:0] res_frame,
  output logic [CNT_W-1:0]   res_visits
);
  localparam int HALF = VPN_W / 2;

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_KEY, S_FRAME, S_LINK} state_t;

  state_t             state;
  logic [VPN_W-1:0]   vpn_q;
  logic [AW-1:0]      ptr_q;
  logic [CNT_W-1:0]   visits;
  logic [HALF-1:0]    fold;
  logic [IDX_W-1:0]   bucket;
  logic [AW-1:0]      link;
  logic               key_match;

  assign fold      = vpn_q[VPN_W-1:HALF] ^ vpn_q[HALF-1:0];
  assign bucket    = fold[IDX_W-1:0];
  assign link      = rd_data[AW-1:0];
  assign key_match = (rd_data == DW'(vpn_q));
  assign busy      = (state != S_IDLE);
  assign rd_req    = busy;

  always_comb begin
    case (state)
      S_HEAD:  rd_addr = bucket_base + AW'(bucket);
      S_FRAME: rd_addr = ptr_q + AW'(1);
      S_LINK:  rd_addr = ptr_q + AW'(2);
      default: rd_addr = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      vpn_q       <= '0;
      ptr_q       <= '0;
      visits      <= '0;
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_fault   <= 1'b0;
      res_overrun <= 1'b0;
      res_frame   <= '0;
      res_visits  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          visits <= '0;
          state  <= S_HEAD;
        end
        S_HEAD, S_LINK: if (rd_ack) begin
          if (link == '0 || visits == max_len) begin
            res_valid   <= 1'b1;
            res_hit     <= 1'b0;
            res_fault   <= 1'b1;
            res_overrun <= (link != '0);
            res_frame   <= '0;
            res_visits  <= visits;
            state       <= S_IDLE;
          end else begin
            ptr_q <= link;
            state <= S_KEY;
          end
        end
        S_KEY: if (rd_ack) begin
          visits <= visits + 1'b1;
          state  <= key_match ? S_FRAME : S_LINK;
        end
        S_FRAME: if (rd_ack) begin
          res_valid   <= 1'b1;
          res_hit     <= 1'b1;
          res_fault   <= 1'b0;
          res_overrun <= 1'b0;
          res_frame   <= rd_data[FRAME_W-1:0];
          res_visits  <= visits;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R8
  AST_TAKE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_fault)); // R6
  AST_FAULT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_frame == '0); // R4
  AST_OVERRUN_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_overrun |-> res_fault && res_visits == max_len); // R5
  AST_VISITS_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_visits <= max_len); // R5
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vpn = '0;
  logic [11:0] bucket_base = 12'h100;
  logic [7:0]  max_len = 8'd8;
  logic        busy, rd_req, rd_ack, res_valid, res_hit, res_fault, res_overrun;
  logic [11:0] rd_addr, res_frame;
  logic [15:0] rd_data;
  logic [7:0]  res_visits;

  logic [15:0] mem [0:4095];
  int lat = 2;
  int wait_cnt = 0;
  int nreads = 0;
  logic [11:0] first_addr = '0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .bucket_base(bucket_base), .max_len(max_len), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
    .res_overrun(res_overrun), .res_frame(res_frame), .res_visits(res_visits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    rd_ack  = 1'b0;
    rd_data = '0;
  end

  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      wait_cnt = wait_cnt + 1;
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        rd_ack   = 1'b1;
        rd_data  = mem[rd_addr];
        if (nreads == 0) first_addr = rd_addr;
        nreads = nreads + 1;
      end
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary_and_end();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] hash_of(input logic [15:0] v);
    logic [7:0] f;
    f = v[15:8] ^ v[7:0];
    return f[3:0];
  endfunction

  task automatic put(input logic [11:0] a, input logic [15:0] key,
                     input logic [15:0] frm, input logic [15:0] nxt);
    mem[a]      = key;
    mem[a + 1]  = frm;
    mem[a + 2]  = nxt;
  endtask

  task automatic launch(input logic [15:0] v);
    nreads = 0;
    @(negedge clk);
    req_vpn   = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (res_valid) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // vpn, cap, hit, overrun, frame, visits
  localparam logic [45:0] VEC [0:NV-1] = '{
    {16'h1234, 8'd8, 1'b1, 1'b0, 12'h0A1, 8'd1},
    {16'h0016, 8'd8, 1'b1, 1'b0, 12'h0B2, 8'd2},
    {16'h0006, 8'd8, 1'b1, 1'b0, 12'h0D3, 8'd3},
    {16'h0106, 8'd8, 1'b0, 1'b0, 12'h000, 8'd0},
    {16'h0107, 8'd8, 1'b0, 1'b0, 12'h000, 8'd3},
    {16'h2604, 8'd8, 1'b1, 1'b0, 12'h111, 8'd1},
    {16'h0009, 8'd5, 1'b0, 1'b1, 12'h000, 8'd5},
    {16'h0006, 8'd3, 1'b1, 1'b0, 12'h0D3, 8'd3},
    {16'h0107, 8'd3, 1'b0, 1'b0, 12'h000, 8'd3},
    {16'h0107, 8'd2, 1'b0, 1'b1, 12'h000, 8'd2},
    {16'h1234, 8'd0, 1'b0, 1'b1, 12'h000, 8'd0}
  };

  initial begin
    bit ok;
    int extra;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h106] = 16'h0200;
    mem[12'h102] = 16'h0230;
    mem[12'h109] = 16'h0250;
    put(12'h200, 16'h1234, 16'h00A1, 16'h0210);
    put(12'h210, 16'h0016, 16'h00B2, 16'h0220);
    put(12'h220, 16'h0006, 16'h00D3, 16'h0000);
    put(12'h230, 16'h2604, 16'h0111, 16'h0240);
    put(12'h240, 16'h2604, 16'h0222, 16'h0000);
    put(12'h250, 16'h0909, 16'h00AA, 16'h0260);
    put(12'h260, 16'h0A0A, 16'h00BB, 16'h0250);

    repeat (3) @(negedge clk);
    chk("R9 busy in reset", 32'(busy), 0);
    chk("R9 rd_req in reset", 32'(rd_req), 0);
    chk("R9 res_valid in reset", 32'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", 32'(busy), 0);

    for (int k = 0; k < NV; k++) begin
      logic [15:0] v;
      v       = VEC[k][45:30];
      max_len = VEC[k][29:22];
      lat     = 1 + (k % 3);
      launch(v);
      wait_result(ok);
      chk("R6 result arrives", 32'(ok), 1);
      chk("R1 first read is bucket head", 32'(first_addr), 32'(12'h100 + 12'(hash_of(v))));
      chk("R6 hit flag", 32'(res_hit), 32'(VEC[k][21]));
      chk("R6 exactly one outcome", 32'(res_hit ^ res_fault), 1);
      chk("R5 overrun flag", 32'(res_overrun), 32'(VEC[k][20]));
      chk("R3 R4 frame", 32'(res_frame), 32'(VEC[k][19:8]));
      chk("R4 R5 visits", 32'(res_visits), 32'(VEC[k][7:0]));
      @(negedge clk);
      chk("R6 pulse one cycle", 32'(res_valid), 0);
      chk("R2 read count", nreads, 1 + 2 * int'(VEC[k][7:0]));
    end

    // R7: request during a search is ignored
    max_len = 8'd8;
    lat = 3;
    launch(16'h1234);
    chk("R7 busy after accept", 32'(busy), 1);
    @(negedge clk);
    req_vpn   = 16'h0016;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(ok);
    chk("R7 first result arrives", 32'(ok), 1);
    chk("R7 result belongs to first request", 32'(res_frame), 32'h0A1);
    chk("R2 R7 read count of first request", nreads, 3);
    @(negedge clk);
    chk("R7 idle after result", 32'(busy), 0);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      if (res_valid || rd_req) extra = extra + 1;
      @(negedge clk);
    end
    chk("R7 ignored request gave no activity", extra, 0);

    // R1: moving the bucket array moves the head read
    bucket_base = 12'h300;
    mem[12'h306] = 16'h0210;
    launch(16'h0016);
    wait_result(ok);
    chk("R1 head read at moved base", 32'(first_addr), 32'h306);
    chk("R1 walk from moved base", 32'(res_frame), 32'h0B2);
    chk("R1 visits from moved base", 32'(res_visits), 1);

    summary_and_end();
  end
endmodule